// File: doc/BRIEF.md
# Staged Dual-Output Switch-On Delay

This block drives four independent channels. Each channel reads a three-position selector that has already been debounced, and it controls two outputs in stages. Putting the selector in position 1 turns on the primary output at once. Putting it in position 2 keeps the primary output on and turns on the secondary output only after a programmable switch-on delay. While the secondary output waits for the delay, a per-channel busy flag is high.

Each channel has its own 16-bit delay register, written through a single register-write port and read back combinationally. The register counts pulses of a shared timebase tick, so the tick rate sets the delay unit. A channel takes its delay value when the delay starts. A later write does not change a delay that is already counting.

The selector is sampled on each rising clock edge. The outputs show the new channel state from the cycle after that edge.

Top module: `stage_delay_switch`

## Requirements
- R1: During and after a synchronous active-low reset, every channel has `out_pri`, `out_sec`, `busy` and `sel_err` low, and every delay register reads back 0.
- R2: Sampling selector code 01 (position 1) makes `out_pri` high and `out_sec` and `busy` low in the next cycle.
- R3: Moving from position 1 to position 2 (code 10) with a delay D > 0 raises `busy` and keeps `out_pri` high. The counter decrements only on tick pulses sampled while `busy` is high. `out_sec` rises, and `busy` falls, in the cycle after the edge that samples the D-th such tick.
- R4: Moving from position 2 back to position 1 drops `out_sec` and `busy` in the next cycle, while `out_pri` stays high.
- R5: Sampling position 0 (code 00) drops `out_pri`, `out_sec` and `busy` in the next cycle and abandons any running delay.
- R6: A direct step from position 0 to position 2 turns `out_pri` on in the next cycle and starts the full delay, exactly as a move through position 1 would.
- R7: Going from 2 to 1 and back to 2 while a delay is running restarts the delay from the full register value.
- R8: With a delay value of 0, `out_sec` rises in the same cycle as `out_pri` when position 2 is reached, and `busy` never rises.
- R9: Selector code 11 is handled as position 0, and `sel_err` is high in the cycle after each edge that samples code 11, and low otherwise.
- R10: A write with `wr_en` high stores `wr_data` into the register selected by `wr_addr` (channel index 0 to 3). `rd_data` shows the register at `rd_addr` from the next cycle on, and no other register changes.
- R11: A register write only affects later delay starts. It does not alter a running delay, and a write in the same cycle as a start is not used by that start.
- R12: Channels are independent: the selector, delay and state of one channel have no effect on another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Shared timebase pulse, one cycle per delay unit |
| sel | input | 8 | Selector codes, 2 bits per channel; channel k at bits [2k+1:2k] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Channel index of the register to write |
| wr_data | input | 16 | Delay value to write, in ticks |
| rd_addr | input | 2 | Channel index of the register to read |
| rd_data | output | 16 | Readback of the addressed delay register |
| out_pri | output | 4 | Primary (first-stage) output per channel |
| out_sec | output | 4 | Secondary (delayed) output per channel |
| busy | output | 4 | High while the channel's delay is counting |
| sel_err | output | 4 | One-cycle flag for an invalid selector code |

## Verification
Two things can happen on the same edge in this block: a register write and a delay start that reads the same register. The bench writes a channel's register in the very cycle its selector reaches position 2. It expects the delay to run with the old value and the readback to show the new one. It also rewrites a register while that channel's delay is counting and expects the expiry cycle to stay where it was. A behavioural model that snapshots the register only at a start decides the expected cycle on each clock.

// File: rtl/stg_pkg.sv
// Package: shared types and helpers for the staged switch-on delay block.
// Assumes selector codes are two bits wide; code 2'b11 is invalid.
package stg_pkg;

    typedef enum logic [1:0] {
        POS_ZERO = 2'd0,
        POS_ONE  = 2'd1,
        POS_TWO  = 2'd2
    } stg_pos_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ONE  = 2'd1,
        ST_WAIT = 2'd2,
        ST_BOTH = 2'd3
    } stg_state_e;

    // Map a raw selector code onto a position; the invalid code reads as zero.
    function automatic stg_pos_e decode_pos(input logic [1:0] code);
        case (code)
            2'd1:    return POS_ONE;
            2'd2:    return POS_TWO;
            default: return POS_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/stg_sel_decode.sv
// Selector decoder: turns a raw 2-bit code into a position and registers a
// one-cycle error flag for each sampled invalid code.
// Assumes the code is already debounced and synchronous to clk.
module stg_sel_decode
    import stg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_i,
    output stg_pos_e   pos_o,
    output logic       err_o
);

    // Combinational position decode.
    always_comb pos_o = decode_pos(code_i);

    // Register the invalid-code flag for exactly the cycle after the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= (code_i == 2'd3);
    end

    a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 2'd3) |=> err_o);
    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i != 2'd3) |=> !err_o);

endmodule

// File: rtl/stg_delay_timer.sv
// Down-counter for one channel's switch-on delay.
// Assumes load and clear are never requested together with a count step that
// must survive; clear wins over load, and load wins over a count step.
module stg_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic         expire_o
);

    logic [W-1:0] cnt_q;

    // Hold, reload or decrement the remaining tick count.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clear_i)               cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (step_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Expiry: the last remaining tick is consumed this cycle.
    always_comb expire_o = step_i && (cnt_q == W'(1));

    a_r11_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i && !step_i) |=> $stable(cnt_q));
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/stg_channel.sv
// One channel: decodes the selector and runs the four-state sequence
// off -> primary -> waiting -> both. The delay value is taken only when a
// delay starts. Assumes delay_i is the stored register value.
module stg_channel
    import stg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [1:0]   code_i,
    input  logic [W-1:0] delay_i,
    output logic         pri_o,
    output logic         sec_o,
    output logic         busy_o,
    output logic         err_o
);

    stg_pos_e   pos;
    stg_state_e state_q, state_d;
    logic       start, expire, step;

    stg_sel_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code_i),
        .pos_o  (pos),
        .err_o  (err_o)
    );

    // A delay starts when position 2 is reached from off or stage one.
    always_comb start = (pos == POS_TWO) && (state_q == ST_OFF || state_q == ST_ONE);
    // Ticks count only while waiting and the selector still holds position 2.
    always_comb step  = tick_i && (state_q == ST_WAIT) && (pos == POS_TWO);

    stg_delay_timer #(.W(W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (pos != POS_TWO),
        .load_i     (start),
        .load_val_i (delay_i),
        .step_i     (step),
        .expire_o   (expire)
    );

    // Next-state selection from the sampled position.
    always_comb begin
        state_d = state_q;
        case (pos)
            POS_ZERO: state_d = ST_OFF;
            POS_ONE:  state_d = ST_ONE;
            default: begin
                if (start)       state_d = (delay_i == '0) ? ST_BOTH : ST_WAIT;
                else if (expire) state_d = ST_BOTH;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        pri_o  = (state_q != ST_OFF);
        sec_o  = (state_q == ST_BOTH);
        busy_o = (state_q == ST_WAIT);
    end

    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_ZERO) |=> (!pri_o && !sec_o && !busy_o));
    a_r2_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == POS_ONE) |=> (pri_o && !sec_o && !busy_o));
    a_r3_sec_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_o) |-> ($past(pos) == POS_TWO));
    a_r3_sec_implies_pri: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o |-> (pri_o && !busy_o));
    a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (start && delay_i == '0) |=> (sec_o && pri_o));
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && delay_i != '0) |=> (busy_o && !sec_o));

endmodule

// File: rtl/stg_regfile.sv
// Delay register file: one W-bit register per channel, single write port,
// combinational readback. Assumes addresses are always below N.
module stg_regfile #(
    parameter int N  = 4,
    parameter int W  = 16,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [W-1:0]        wr_data_i,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [W-1:0]        rd_data_o,
    output logic [N-1:0][W-1:0] regs_o
);

    logic [N-1:0][W-1:0] regs_q;

    // One register per channel, each with its own address match.
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs_q[g] <= '0;
            else if (wr_en_i && wr_addr_i == AW'(g))     regs_q[g] <= wr_data_i;
        end
    end

    // Readback mux and flat view for the channels.
    always_comb begin
        rd_data_o = regs_q[rd_addr_i];
        regs_o    = regs_q;
    end

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (regs_q[$past(wr_addr_i)] == $past(wr_data_i)));
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_q));

endmodule

// File: rtl/stage_delay_switch.sv
// Top: N independent staged switch-on delay channels that share a timebase
// tick and a delay register file. Assumes sel is debounced and synchronous.
module stage_delay_switch
    import stg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DLY_W  = 16,
    localparam int AW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [2*NUM_CH-1:0] sel,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DLY_W-1:0]    wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DLY_W-1:0]    rd_data,
    output logic [NUM_CH-1:0]   out_pri,
    output logic [NUM_CH-1:0]   out_sec,
    output logic [NUM_CH-1:0]   busy,
    output logic [NUM_CH-1:0]   sel_err
);

    logic [NUM_CH-1:0][DLY_W-1:0] dly;

    stg_regfile #(.N(NUM_CH), .W(DLY_W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .regs_o    (dly)
    );

    // One channel per selector pair.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        stg_channel #(.W(DLY_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .code_i  (sel[2*g +: 2]),
            .delay_i (dly[g]),
            .pri_o   (out_pri[g]),
            .sec_o   (out_sec[g]),
            .busy_o  (busy[g]),
            .err_o   (sel_err[g])
        );
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (out_pri == '0 && out_sec == '0 && busy == '0 && sel_err == '0));

endmodule

// File: tb/stage_delay_switch_tb.sv
// Bench: a behavioural per-channel model, stepped on each rising edge and
// compared with the design on every falling edge.
module stage_delay_switch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  sel = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  out_pri, out_sec, busy, sel_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Model state: 0 off, 1 primary, 2 waiting, 3 both.
    int m_st [NCH];
    int m_cnt[NCH];
    int m_reg[NCH];
    bit m_err[NCH];

    stage_delay_switch u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .out_pri(out_pri), .out_sec(out_sec), .busy(busy), .sel_err(sel_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        running = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            int code;
            code = (sel >> (2*c)) & 3;
            if (!rst_n) begin
                m_st[c] = 0; m_cnt[c] = 0; m_reg[c] = 0; m_err[c] = 0;
            end else begin
                m_err[c] = (code == 3);
                if (code == 3 || code == 0) begin
                    m_st[c] = 0; m_cnt[c] = 0;
                end else if (code == 1) begin
                    m_st[c] = 1;
                end else if (m_st[c] <= 1) begin
                    if (m_reg[c] == 0) m_st[c] = 3;
                    else begin m_st[c] = 2; m_cnt[c] = m_reg[c]; end
                end else if (m_st[c] == 2 && tick) begin
                    if (m_cnt[c] == 1) m_st[c] = 3;
                    else m_cnt[c]--;
                end
            end
        end
        if (rst_n && wr_en) m_reg[wr_addr] = wr_data;
    end

    // Compare design against model on every falling edge.
    always @(negedge clk) begin
        if (running && !done) begin
            for (int c = 0; c < NCH; c++) begin
                bit ep, es, eb;
                ep = (m_st[c] != 0); es = (m_st[c] == 3); eb = (m_st[c] == 2);
                checks++;
                if (out_pri[c] !== ep || out_sec[c] !== es || busy[c] !== eb
                    || sel_err[c] !== m_err[c]) begin
                    failures++;
                    $display("FAIL %s ch%0d t=%0t pri/sec/busy/err act=%b%b%b%b exp=%b%b%b%b",
                             cur_req, c, $time, out_pri[c], out_sec[c], busy[c], sel_err[c],
                             ep, es, eb, m_err[c]);
                end
            end
            checks++;
            if (rd_data !== 16'(m_reg[rd_addr])) begin
                failures++;
                $display("FAIL %s rd_data addr=%0d act=%0d exp=%0d",
                         cur_req, rd_addr, rd_data, m_reg[rd_addr]);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic set_sel(input int c, input int code);
        sel[2*c +: 2] = 2'(code);
    endtask

    task automatic pulse_ticks(input int n, input int gap);
        repeat (n) begin tick = 1'b1; step(1); tick = 1'b0; step(gap); end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d); step(1); wr_en = 1'b0;
    endtask

    // Explicit point check with a requirement tag.
    task automatic expect_bit(input string req, input logic act, input logic exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s explicit act=%b exp=%b", req, act, exp);
        end
        step(0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(2);

        cur_req = "R10";
        wr(0, 3); wr(1, 0); wr(2, 5); wr(3, 2);
        for (int a = 0; a < NCH; a++) begin rd_addr = 2'(a); step(2); end

        cur_req = "R2";
        set_sel(0, 1); step(3);
        cur_req = "R3";
        set_sel(0, 2); step(2);
        pulse_ticks(4, 2);
        cur_req = "R4";
        set_sel(0, 1); step(2);
        cur_req = "R5";
        set_sel(0, 2); step(1); pulse_ticks(1, 1);
        set_sel(0, 0); step(2); pulse_ticks(3, 1);

        cur_req = "R6";
        set_sel(2, 2); step(1);
        expect_bit("R6", out_pri[2], 1'b1);
        expect_bit("R6", busy[2], 1'b1);
        pulse_ticks(6, 1);
        set_sel(2, 0); step(2);

        cur_req = "R7";
        set_sel(3, 1); step(1); set_sel(3, 2); step(1);
        pulse_ticks(1, 1);
        set_sel(3, 1); step(1); set_sel(3, 2); step(1);
        pulse_ticks(1, 1);
        expect_bit("R7", out_sec[3], 1'b0);
        pulse_ticks(2, 1);
        expect_bit("R7", out_sec[3], 1'b1);
        set_sel(3, 0); step(1);

        cur_req = "R8";
        set_sel(1, 2); step(1);
        expect_bit("R8", out_sec[1], 1'b1);
        expect_bit("R8", busy[1], 1'b0);
        set_sel(1, 0); step(1);

        cur_req = "R9";
        set_sel(0, 1); step(2);
        set_sel(0, 3); step(1);
        expect_bit("R9", sel_err[0], 1'b1);
        expect_bit("R9", out_pri[0], 1'b0);
        set_sel(0, 1); step(1);
        expect_bit("R9", sel_err[0], 1'b0);
        set_sel(0, 0); step(1);

        cur_req = "R11";
        rd_addr = 2'd2;
        set_sel(2, 2); step(1);
        wr(2, 1);
        pulse_ticks(2, 1);
        expect_bit("R11", out_sec[2], 1'b0);
        set_sel(2, 0); step(1);
        set_sel(0, 2); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd0; step(1); wr_en = 1'b0;
        rd_addr = 2'd0;
        expect_bit("R11", busy[0], 1'b1);
        pulse_ticks(3, 1);
        set_sel(0, 0); step(1);

        cur_req = "R12";
        for (int c = 0; c < NCH; c++) begin wr(c, c + 1); end
        for (int i = 0; i < 400; i++) begin
            sel = 8'($urandom);
            if (($urandom % 4) != 0) sel = sel & 8'h55 | (sel & 8'h55) << 1 & 8'hAA & ~(sel << 1);
            tick = 1'($urandom % 2);
            wr_en = (($urandom % 16) == 0);
            wr_addr = 2'($urandom);
            wr_data = 16'($urandom % 6);
            rd_addr = 2'($urandom);
            step(1 + ($urandom % 3));
        end
        wr_en = 1'b0; tick = 1'b0; sel = '0;
        step(2);

        cur_req = "R1";
        rst_n = 1'b0; step(2);
        expect_bit("R1", |{out_pri, out_sec, busy, sel_err}, 1'b0);
        rst_n = 1'b1; step(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule